// File: doc/BRIEF.md
# Key-Protected Register Write Gate

This block stands between a simple register bus and a configuration register file. It decides, one write at a time, whether the write may reach its target register. Reads always pass through, and status is reported on reads. Two protection schemes are provided.

In the first scheme, each of up to four guarded target registers is paired with its own lock register and its own key. Software opens a slot by writing the exact key to that slot's lock register. The slot then stays open for a short window of bus cycles. The window closes on the first of three events: a single accepted write to the target, a zero or wrong value written to the lock register, or the end of the window.

In the second scheme, the target registers inside a configurable address range are guarded together by a global two-key sequence. The first key must be written to the first kick register, then the second key to the second kick register. The range remains writable until zero is written to the first kick register and then to the second.

Writes that the gate drops set a sticky violation flag. Software reads that flag in a status register and clears it by writing a one to its bit.

Top module: `key_write_gate`

## Requirements
- R1: After reset every slot is locked, the kick range is closed and the violation flag is clear, so the status register reads zero.
- R2: A write to a slot's target register is forwarded (`tgt_we` high in the same cycle) only while that slot is open. A slot opens only when its exact key is written to its lock register.
- R3: After the key write, a target write is accepted in any of the following 8 bus cycles (cycles 1 to 8). From cycle 9 onward it is dropped.
- R4: One accepted target write closes the slot at once, so a second write inside the same window is dropped.
- R5: Writing zero to an open slot's lock register relocks it immediately. Writing a wrong nonzero key also leaves the slot locked.
- R6: The kick range (default 0x40 to 0x4F) opens only after the first key is written to kick register 0 (0x30) and then the second key to kick register 1 (0x31). The keys in the reverse order do not open it.
- R7: Writes to the lock registers (0x20 to 0x23), the kick registers and the status register (0x3F) are never forwarded.
- R8: A wrong nonzero value written to either kick register clears partial progress. The same write closes the range if it is open.
- R9: The range closes after zero is written to kick register 0 and then to kick register 1. Between those two writes it stays writable.
- R10: Every dropped write to a guarded register sets the sticky violation flag. Writing 1 to status bit 5 clears it. Writing 0 to that bit leaves it set.
- R11: Reads are never gated. A read of any address outside the gate's own registers returns `tgt_rdata`, whether the address is locked or not.
- R12: The status register carries slot-open flags in bits 3:0 (slot i in bit i), kick-open in bit 4 and violation in bit 5. A lock register reads back its slot's open flag in bit 0, and a kick register reads back kick-open in bit 0.
- R13: Addresses that are not guarded are always forwarded, with `tgt_addr` and `tgt_wdata` equal to the bus values. A slot target is governed only by its own slot, even while the kick range is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for this cycle |
| addr | input | 8 | Bus address, for both reads and writes |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Read data (combinational) |
| tgt_we | output | 1 | Write strobe forwarded to the register file |
| tgt_addr | output | 8 | Address presented to the register file |
| tgt_wdata | output | 32 | Write data presented to the register file |
| tgt_rdata | input | 32 | Read data returned by the register file |

Slot state machine: states LOCKED and OPEN. The transitions are:
- key-match: LOCKED to OPEN.
- rekey: OPEN to OPEN, which reloads the window.
- relock: a zero or wrong key, OPEN to LOCKED.
- consume: an accepted target write, OPEN to LOCKED.
- expire: the window runs out, OPEN to LOCKED.

Kick state machine: states IDLE, HALF, OPEN and SHUT. The transitions are:
- first-key: IDLE to HALF, or HALF to HALF.
- second-key: HALF to OPEN.
- abort: any wrong value, which returns to IDLE.
- close-begin: zero to kick register 0, OPEN to SHUT.
- resume: the first key again, SHUT to OPEN.
- close-end: zero to kick register 1, SHUT to IDLE.

## Verification
The assertions take the following for granted about the inputs and the configuration:
- Every configured key is nonzero.
- The lock, kick, status and target addresses are all distinct.
- The bus presents at most one write per cycle.
- `tgt_rdata` depends only on `tgt_addr`.

The stimulus stays within these limits. It uses the default address map, drives one transaction per negative clock edge, and never writes a key value that collides with zero. The register-file model is a pure function of the address.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;

    typedef enum logic {
        SLOT_LOCKED,
        SLOT_OPEN
    } slot_st_t;

    typedef enum logic [1:0] {
        KICK_IDLE,
        KICK_HALF,
        KICK_OPEN,
        KICK_SHUT
    } kick_st_t;

endpackage

// File: rtl/kgate_slot.sv
module kgate_slot
    import key_gate_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          WINDOW = 8,
    parameter logic [DATA_W-1:0] KEY = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              prot_wr,
    output logic              is_open
);

    localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW - 1);

    slot_st_t         st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SLOT_LOCKED;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            SLOT_LOCKED: begin
                if (key_wr && key_data == KEY) begin
                    st_nx  = SLOT_OPEN;
                    cnt_nx = CNT_LOAD;
                end
            end
            SLOT_OPEN: begin
                if (key_wr) begin
                    if (key_data == KEY) begin
                        cnt_nx = CNT_LOAD;
                    end else begin
                        st_nx  = SLOT_LOCKED;
                        cnt_nx = '0;
                    end
                end else if (prot_wr || cnt == '0) begin
                    st_nx  = SLOT_LOCKED;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            default: begin
                st_nx  = SLOT_LOCKED;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        is_open = (st == SLOT_OPEN);
    end

endmodule

// File: rtl/kgate_kick.sv
module kgate_kick
    import key_gate_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0 = '1,
    parameter logic [DATA_W-1:0] KEY1 = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [DATA_W-1:0] wdata,
    output logic              kick_open
);

    kick_st_t st, st_nx;
    logic     zero, k0, k1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= KICK_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        zero  = (wdata == '0);
        k0    = (wdata == KEY0);
        k1    = (wdata == KEY1);
        st_nx = st;
        unique case (st)
            KICK_IDLE: begin
                if (wr0 && k0) st_nx = KICK_HALF;
            end
            KICK_HALF: begin
                if (wr0)      st_nx = k0 ? KICK_HALF : KICK_IDLE;
                else if (wr1) st_nx = k1 ? KICK_OPEN : KICK_IDLE;
            end
            KICK_OPEN: begin
                if (wr0)      st_nx = zero ? KICK_SHUT : (k0 ? KICK_OPEN : KICK_IDLE);
                else if (wr1) st_nx = (zero || k1) ? KICK_OPEN : KICK_IDLE;
            end
            KICK_SHUT: begin
                if (wr0)      st_nx = k0 ? KICK_OPEN : (zero ? KICK_SHUT : KICK_IDLE);
                else if (wr1) st_nx = k1 ? KICK_SHUT : KICK_IDLE;
            end
            default: st_nx = KICK_IDLE;
        endcase
    end

    always_comb begin
        kick_open = (st == KICK_OPEN) || (st == KICK_SHUT);
    end

endmodule

// File: rtl/key_write_gate.sv
module key_write_gate
    import key_gate_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_LOCK = 4,
    parameter int WINDOW = 8,
    parameter logic [N_LOCK*ADDR_W-1:0] TGT_MAP  = {8'h13, 8'h12, 8'h11, 8'h10},
    parameter logic [N_LOCK*ADDR_W-1:0] LOCK_MAP = {8'h23, 8'h22, 8'h21, 8'h20},
    parameter logic [N_LOCK*DATA_W-1:0] KEY_MAP  = {32'h7A3C_19E4, 32'h5E02_B6D1,
                                                    32'h2C9F_4A07, 32'h1B66_D3F8},
    parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h30,
    parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h31,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h3F,
    parameter logic [ADDR_W-1:0] KRANGE_LO  = 8'h40,
    parameter logic [ADDR_W-1:0] KRANGE_HI  = 8'h4F,
    parameter logic [DATA_W-1:0] KICK0_KEY  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KICK1_KEY  = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tgt_we,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata
);

    localparam int KOPEN_BIT = N_LOCK;
    localparam int VIOL_BIT  = N_LOCK + 1;

    logic [N_LOCK-1:0] hit_tgt, hit_lock, slot_open;
    logic hit_k0, hit_k1, hit_stat;
    logic kick_open, violation;
    logic any_tgt, tgt_ok, in_kr, local_hit, guarded, pass;

    for (genvar i = 0; i < N_LOCK; i++) begin : g_slot
        assign hit_tgt[i]  = (addr == TGT_MAP[i*ADDR_W +: ADDR_W]);
        assign hit_lock[i] = (addr == LOCK_MAP[i*ADDR_W +: ADDR_W]);
        kgate_slot #(
            .DATA_W (DATA_W),
            .WINDOW (WINDOW),
            .KEY    (KEY_MAP[i*DATA_W +: DATA_W])
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_wr   (wr_en && hit_lock[i]),
            .key_data (wdata),
            .prot_wr  (wr_en && hit_tgt[i]),
            .is_open  (slot_open[i])
        );
    end

    kgate_kick #(
        .DATA_W (DATA_W),
        .KEY0   (KICK0_KEY),
        .KEY1   (KICK1_KEY)
    ) u_kick (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr0       (wr_en && hit_k0),
        .wr1       (wr_en && hit_k1),
        .wdata     (wdata),
        .kick_open (kick_open)
    );

    always_comb begin
        hit_k0    = (addr == KICK0_ADDR);
        hit_k1    = (addr == KICK1_ADDR);
        hit_stat  = (addr == STAT_ADDR);
        any_tgt   = |hit_tgt;
        tgt_ok    = |(hit_tgt & slot_open);
        in_kr     = (addr >= KRANGE_LO) && (addr <= KRANGE_HI);
        local_hit = (|hit_lock) || hit_k0 || hit_k1 || hit_stat;
        guarded   = any_tgt || in_kr;
        pass      = any_tgt ? tgt_ok : (in_kr ? kick_open : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            violation <= 1'b0;
        end else if (wr_en && !local_hit && guarded && !pass) begin
            violation <= 1'b1;
        end else if (wr_en && hit_stat && wdata[VIOL_BIT]) begin
            violation <= 1'b0;
        end
    end

    always_comb begin
        tgt_we    = wr_en && !local_hit && pass;
        tgt_addr  = addr;
        tgt_wdata = wdata;
        rdata     = tgt_rdata;
        if (hit_stat) begin
            rdata                 = '0;
            rdata[N_LOCK-1:0]     = slot_open;
            rdata[KOPEN_BIT]      = kick_open;
            rdata[VIOL_BIT]       = violation;
        end else if (hit_k0 || hit_k1) begin
            rdata    = '0;
            rdata[0] = kick_open;
        end else begin
            for (int i = 0; i < N_LOCK; i++) begin
                if (hit_lock[i]) begin
                    rdata    = '0;
                    rdata[0] = slot_open[i];
                end
            end
        end
    end

endmodule

// File: rtl/key_gate_chk.sv
module key_gate_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WINDOW = 8,
    parameter int VBIT   = 5,
    parameter logic [ADDR_W-1:0] T0    = '0,
    parameter logic [ADDR_W-1:0] L0    = '0,
    parameter logic [ADDR_W-1:0] KICK0 = '0,
    parameter logic [ADDR_W-1:0] KICK1 = '0,
    parameter logic [ADDR_W-1:0] STAT  = '0,
    parameter logic [DATA_W-1:0] KEY1  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] tgt_rdata,
    input logic              tgt_we,
    input logic              slot0_open,
    input logic              kick_open,
    input logic              violation
);

    int run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run <= 0;
        else if (wr_en && addr == L0)   run <= 0;
        else if (slot0_open)            run <= run + 1;
        else                            run <= 0;
    end

    // R2
    slot0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we && addr == T0) |-> slot0_open);

    // R3
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot0_open |-> (run < WINDOW));

    // R4
    accept_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we && addr == T0) |=> !slot0_open);

    // R6
    kick_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kick_open) |-> $past(wr_en && addr == KICK1 && wdata == KEY1));

    // R7
    local_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == KICK0 || addr == KICK1 || addr == STAT || addr == L0)) |-> !tgt_we);

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !(wr_en && addr == STAT && wdata[VBIT])) |=> violation);

    // R11
    read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == T0) |-> (rdata == tgt_rdata));

endmodule

bind key_write_gate key_gate_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WINDOW (WINDOW),
    .VBIT   (N_LOCK + 1),
    .T0     (TGT_MAP[ADDR_W-1:0]),
    .L0     (LOCK_MAP[ADDR_W-1:0]),
    .KICK0  (KICK0_ADDR),
    .KICK1  (KICK1_ADDR),
    .STAT   (STAT_ADDR),
    .KEY1   (KICK1_KEY)
) u_key_gate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .tgt_rdata  (tgt_rdata),
    .tgt_we     (tgt_we),
    .slot0_open (slot_open[0]),
    .kick_open  (kick_open),
    .violation  (violation)
);

// File: tb/test_key_write_gate.sv
module test_key_write_gate;

    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata, tgt_wdata, tgt_rdata;
    logic [7:0]  tgt_addr;
    logic        tgt_we;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign tgt_rdata = {24'hD15EA5, tgt_addr};

    key_write_gate i_key_write_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .tgt_rdata (tgt_rdata)
    );

    function automatic logic [31:0] key_of(int i);
        case (i)
            0:       return 32'h1B66_D3F8;
            1:       return 32'h2C9F_4A07;
            2:       return 32'h5E02_B6D1;
            default: return 32'h7A3C_19E4;
        endcase
    endfunction

    function automatic bit is_local(logic [7:0] a);
        return (a >= 8'h20 && a <= 8'h23) || a == 8'h30 || a == 8'h31 || a == 8'h3F;
    endfunction

    function automatic bit is_slot(logic [7:0] a);
        return a >= 8'h10 && a <= 8'h13;
    endfunction

    function automatic bit is_kr(logic [7:0] a);
        return a >= 8'h40 && a <= 8'h4F;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, output bit fwd);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        #1 fwd = tgt_we;
        @(posedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = a;
        #1 v = rdata;
        @(posedge clk);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit          f;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h3F, v); chk("R1 status", v, 32'h0);
        rd(8'h20, v); chk("R1 lock0", v, 32'h0);

        // Locked sweep over every address
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), 32'h0, f);
            if (is_local(8'(a)))     chk("R7", {31'b0, f}, 32'(0));
            else if (is_slot(8'(a))) chk("R2", {31'b0, f}, 32'(0));
            else if (is_kr(8'(a)))   chk("R6", {31'b0, f}, 32'(0));
            else                     chk("R13", {31'b0, f}, 32'(1));
        end

        // R10: sticky violation and clear
        rd(8'h3F, v); chk("R10 set", v, 32'h20);
        wr(8'h3F, 32'h0, f);
        rd(8'h3F, v); chk("R10 zero keeps", v, 32'h20);
        wr(8'h3F, 32'h20, f);
        rd(8'h3F, v); chk("R10 clear", v, 32'h0);

        // R11: reads pass through while locked
        rd(8'h10, v); chk("R11 slot tgt", v, {24'hD15EA5, 8'h10});
        rd(8'h40, v); chk("R11 kick tgt", v, {24'hD15EA5, 8'h40});

        // R3: window sweep for every slot
        for (int i = 0; i < 4; i++) begin
            for (int d = 1; d <= 10; d++) begin
                wr(8'(8'h20 + i), 32'h0, f);
                wr(8'(8'h20 + i), key_of(i), f);
                idle(d - 1);
                wr(8'(8'h10 + i), 32'hA000_0000 + 32'(d), f);
                chk("R3", {31'b0, f}, 32'(d <= 8));
            end
        end

        // R4: one accepted write closes the window
        wr(8'h21, key_of(1), f);
        wr(8'h11, 32'h1, f); chk("R4 first", {31'b0, f}, 32'd1);
        wr(8'h11, 32'h2, f); chk("R4 second", {31'b0, f}, 32'd0);

        // R5 and R12: relock by zero, wrong key
        wr(8'h3F, 32'h20, f);
        wr(8'h22, key_of(2), f);
        rd(8'h3F, v); chk("R12 status slot2", v, 32'h04);
        rd(8'h22, v); chk("R12 lock read", v, 32'h1);
        wr(8'h22, 32'h0, f);
        rd(8'h3F, v); chk("R5 zero relock", v, 32'h0);
        wr(8'h12, 32'h5, f); chk("R5 dropped", {31'b0, f}, 32'd0);
        wr(8'h22, key_of(2) ^ 32'h1, f);
        wr(8'h12, 32'h5, f); chk("R5 wrong key", {31'b0, f}, 32'd0);
        wr(8'h22, key_of(2), f);
        wr(8'h22, 32'h0000_0055, f);
        wr(8'h12, 32'h5, f); chk("R5 wrong while open", {31'b0, f}, 32'd0);

        // R13: slots independent
        wr(8'h20, key_of(0), f);
        wr(8'h11, 32'h6, f); chk("R13 other slot", {31'b0, f}, 32'd0);
        wr(8'h10, 32'h6, f); chk("R2 own slot", {31'b0, f}, 32'd1);

        // R6: kick order
        wr(8'h3F, 32'h20, f);
        wr(8'h31, K1, f);
        wr(8'h30, K0, f);
        wr(8'h40, 32'h7, f); chk("R6 half", {31'b0, f}, 32'd0);
        rd(8'h3F, v); chk("R6 half status", v, 32'h20);
        wr(8'h31, K1, f);
        rd(8'h3F, v); chk("R12 kick status", v, 32'h30);
        rd(8'h31, v); chk("R12 kick read", v, 32'h1);

        // Kick-open sweep, kick registers skipped
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h30 || a == 8'h31) continue;
            wr(8'(a), 32'h0, f);
            if (is_local(8'(a)))     chk("R7", {31'b0, f}, 32'(0));
            else if (is_slot(8'(a))) chk("R13", {31'b0, f}, 32'(0));
            else if (is_kr(8'(a)))   chk("R6", {31'b0, f}, 32'(1));
            else                     chk("R13", {31'b0, f}, 32'(1));
        end

        // R9: two-step close
        wr(8'h30, 32'h0, f);
        wr(8'h45, 32'h8, f); chk("R9 still open", {31'b0, f}, 32'd1);
        wr(8'h31, 32'h0, f);
        wr(8'h45, 32'h8, f); chk("R9 closed", {31'b0, f}, 32'd0);

        // R8: wrong values abort
        wr(8'h30, K0, f);
        wr(8'h31, 32'h1234_5678, f);
        wr(8'h31, K1, f);
        wr(8'h40, 32'h9, f); chk("R8 partial cleared", {31'b0, f}, 32'd0);
        wr(8'h30, K0, f);
        wr(8'h31, K1, f);
        wr(8'h40, 32'h9, f); chk("R8 open", {31'b0, f}, 32'd1);
        wr(8'h30, 32'h0000_1234, f);
        wr(8'h40, 32'h9, f); chk("R8 open then wrong", {31'b0, f}, 32'd0);

        // R13: forwarded address and data
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h05; wdata = 32'hCAFE_F00D;
        #1;
        chk("R13 wdata", tgt_wdata, 32'hCAFE_F00D);
        chk("R13 addr", {24'b0, tgt_addr}, 32'h05);
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule